// File: doc/BRIEF.md
# Bus-Phase-Gated Memory Address Decoder

This block turns a 16-bit microcontroller address, the read/write line and the bus clock E into the strobes that memories and latches need. A configurable group of the highest address bits is compared against a fixed base value. The next three bits drive a one-of-eight decoder. The decoder gives eight active-low chip selects. The remaining low-order address bits go straight to the selected device.

Every select is qualified by E. During the low phase of E the address is still settling, so no select or strobe is active. While E is high, the matching select drops low. An active-low output enable or an active-low write enable also drops low, chosen by the read/write line.

Address bits that the decoder does not look at are left undecoded. Every address that shares the decoded upper bits therefore lands on the same select. A device smaller than one select window repeats, or aliases, across that window. The block is purely combinational and has no clock or reset.

Top module: `bus_phase_sel_decoder`

## Requirements
- R1: While `bus_e` is 0, all bits of `sel_n` are 1 and both `oe_n` and `we_n` are 1, for any address and any `bus_rd_wr_n`.
- R2: While `bus_e` is 1 and `bus_addr[15]` is 1 (with the defaults, the base-match bit must be 1), exactly one bit of `sel_n` is 0. That bit is the one at index `bus_addr[14:12]`, so `sel_n[i]` is low for i = `bus_addr[14:12]`.
- R3: While `bus_addr[15]` is 0 (base mismatch), all `sel_n` bits, `oe_n` and `we_n` are 1, even with `bus_e` at 1.
- R4: `oe_n` is 0 exactly when a select is low and `bus_rd_wr_n` is 1 (1 means read).
- R5: `we_n` is 0 exactly when a select is low and `bus_rd_wr_n` is 0 (0 means write).
- R6: `dev_addr` always equals `bus_addr[11:0]`, in both phases of E.
- R7: All addresses with the same top four bits produce the same `sel_n`, so each select covers an aliased 4 KB window. For example, 0x9000 and 0x9FFF both assert `sel_n[1]`.
- R8: At most one `sel_n` bit is ever low, and `oe_n` and `we_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_addr | input | 16 | Bus address |
| bus_rd_wr_n | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_e | input | 1 | Bus clock E; high phase is the data phase |
| sel_n | output | 8 | Active-low chip selects, one per decoded window |
| oe_n | output | 1 | Active-low output enable for reads |
| we_n | output | 1 | Active-low write enable for writes |
| dev_addr | output | 12 | Low-order address passed to the selected device |

## Verification
The block holds no state, so a wrong decode shows at the ports in the same cycle the address is applied. The bench sweeps every address in both E phases, so no aliasing slip or mis-indexed select can escape.

Each fault has a distinct signature at the ports:
- A fault in the base comparison shows as selects active in the lower half of the map.
- A fault in the E gating shows as strobes during the setup phase.
- A swapped read/write polarity shows as the wrong enable on every cycle.

// File: rtl/bpsd_pkg.sv
package bpsd_pkg;

  // Kind of bus access seen during the data phase.
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_t;

endpackage

// File: rtl/bpsd_base_match.sv
// Compares the highest address bits against a fixed base value.
module bpsd_base_match #(
  parameter int unsigned BASE_W   = 1,
  parameter int unsigned BASE_VAL = 1
) (
  input  logic [BASE_W-1:0] hi_bits,
  output logic              match
);
  localparam logic [BASE_W-1:0] BASE_P = BASE_W'(BASE_VAL);

  always_comb begin
    match = (hi_bits == BASE_P);
  end
endmodule

// File: rtl/bpsd_onehot_dec.sv
// One-of-N decoder with active-low outputs, all high when disabled.
module bpsd_onehot_dec #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned N_OUT = 1 << SEL_W
) (
  input  logic             en,
  input  logic [SEL_W-1:0] idx,
  output logic [N_OUT-1:0] out_n
);
  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    assign out_n[g] = !(en && (idx == SEL_W'(g)));
  end
endmodule

// File: rtl/bpsd_strobe_gen.sv
// Turns "some select active" plus the read/write line into OE/WE strobes.
module bpsd_strobe_gen
  import bpsd_pkg::*;
(
  input  logic any_sel,
  input  logic rd_wr_n,
  output logic oe_n,
  output logic we_n
);
  acc_kind_t kind;

  always_comb begin
    if (!any_sel)     kind = ACC_NONE;
    else if (rd_wr_n) kind = ACC_READ;
    else              kind = ACC_WRITE;
  end

  always_comb begin
    oe_n = 1'b1;
    we_n = 1'b1;
    case (kind)
      ACC_READ:  oe_n = 1'b0;
      ACC_WRITE: we_n = 1'b0;
      default: ;
    endcase
  end
endmodule

// File: rtl/bus_phase_sel_decoder.sv
// Phase-gated address decoder: base compare, one-of-N select, strobes.
module bus_phase_sel_decoder #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned BASE_W   = 1,
  parameter int unsigned BASE_VAL = 1,
  parameter int unsigned SEL_W    = 3,
  localparam int unsigned N_SEL   = 1 << SEL_W,
  localparam int unsigned LOW_W   = ADDR_W - BASE_W - SEL_W
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd_wr_n,
  input  logic              bus_e,
  output logic [N_SEL-1:0]  sel_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [LOW_W-1:0]  dev_addr
);
  logic base_ok;
  logic dec_en;
  logic any_sel;

  if (BASE_W == 0) begin : g_no_base
    assign base_ok = 1'b1;
  end else begin : g_base
    bpsd_base_match #(
      .BASE_W  (BASE_W),
      .BASE_VAL(BASE_VAL)
    ) base_i (
      .hi_bits(bus_addr[ADDR_W-1 -: BASE_W]),
      .match  (base_ok)
    );
  end

  // Data phase of E and base match both enable the decoder.
  assign dec_en = bus_e && base_ok;

  bpsd_onehot_dec #(
    .SEL_W(SEL_W)
  ) dec_i (
    .en   (dec_en),
    .idx  (bus_addr[LOW_W +: SEL_W]),
    .out_n(sel_n)
  );

  assign any_sel = !(&sel_n);

  bpsd_strobe_gen strobe_i (
    .any_sel(any_sel),
    .rd_wr_n(bus_rd_wr_n),
    .oe_n   (oe_n),
    .we_n   (we_n)
  );

  assign dev_addr = bus_addr[LOW_W-1:0];
endmodule

// File: rtl/bpsd_checker.sv
// Port-level checks, attached to the decoder by bind.
module bpsd_checker #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned BASE_W   = 1,
  parameter int unsigned BASE_VAL = 1,
  parameter int unsigned SEL_W    = 3,
  localparam int unsigned N_SEL   = 1 << SEL_W
) (
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd_wr_n,
  input logic              bus_e,
  input logic [N_SEL-1:0]  sel_n,
  input logic              oe_n,
  input logic              we_n
);
  logic base_hit;

  if (BASE_W == 0) begin : g_nb
    assign base_hit = 1'b1;
  end else begin : g_b
    assign base_hit = (bus_addr[ADDR_W-1 -: BASE_W] == BASE_W'(BASE_VAL));
  end

  always_comb begin
    if (!$isunknown({bus_addr, bus_rd_wr_n, bus_e})) begin
      if (!bus_e) AST_IDLE_IN_SETUP: assert (&sel_n && oe_n && we_n);            // R1
      if (bus_e && base_hit) AST_ONE_SEL_IN_WINDOW: assert ($countones(~sel_n) == 1); // R2
      if (!base_hit) AST_QUIET_OFF_BASE: assert (&sel_n && oe_n && we_n);         // R3
      AST_OE_ON_READ: assert (oe_n == !(!(&sel_n) && bus_rd_wr_n));               // R4
      AST_WE_ON_WRITE: assert (we_n == !(!(&sel_n) && !bus_rd_wr_n));             // R5
      AST_AT_MOST_ONE_SEL: assert ($countones(~sel_n) <= 1);                      // R8
      AST_STROBES_EXCLUSIVE: assert (oe_n || we_n);                               // R8
    end
  end
endmodule

bind bus_phase_sel_decoder bpsd_checker #(
  .ADDR_W  (ADDR_W),
  .BASE_W  (BASE_W),
  .BASE_VAL(BASE_VAL),
  .SEL_W   (SEL_W)
) chk_i (
  .bus_addr   (bus_addr),
  .bus_rd_wr_n(bus_rd_wr_n),
  .bus_e      (bus_e),
  .sel_n      (sel_n),
  .oe_n       (oe_n),
  .we_n       (we_n)
);

// File: tb/bus_phase_sel_decoder_tb_top.sv
module bus_phase_sel_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = 16'h0000;
  logic        bus_rd_wr_n = 1'b1;
  logic        bus_e = 1'b0;
  logic [7:0]  sel_n;
  logic        oe_n;
  logic        we_n;
  logic [11:0] dev_addr;

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  bus_phase_sel_decoder dut_i (
    .bus_addr   (bus_addr),
    .bus_rd_wr_n(bus_rd_wr_n),
    .bus_e      (bus_e),
    .sel_n      (sel_n),
    .oe_n       (oe_n),
    .we_n       (we_n),
    .dev_addr   (dev_addr)
  );

  // Vector fields: {e, rd_wr_n, addr[15:0], exp_sel[7:0], exp_oe, exp_we}
  localparam int NV = 10;
  localparam logic [27:0] VEC [NV] = '{
    {1'b0, 1'b1, 16'h8000, 8'hFF, 1'b1, 1'b1},  // R1 setup phase
    {1'b1, 1'b1, 16'h8000, 8'hFE, 1'b0, 1'b1},  // R2 R4 sel 0 read
    {1'b1, 1'b0, 16'hF123, 8'h7F, 1'b1, 1'b0},  // R2 R5 sel 7 write
    {1'b1, 1'b1, 16'h7FFF, 8'hFF, 1'b1, 1'b1},  // R3 just below base
    {1'b1, 1'b0, 16'h0000, 8'hFF, 1'b1, 1'b1},  // R3 bottom
    {1'b1, 1'b1, 16'h9000, 8'hFD, 1'b0, 1'b1},  // R7 window start
    {1'b1, 1'b1, 16'h9FFF, 8'hFD, 1'b0, 1'b1},  // R7 window end aliases
    {1'b1, 1'b0, 16'hA800, 8'hFB, 1'b1, 1'b0},  // R5 sel 2 write
    {1'b0, 1'b0, 16'hC000, 8'hFF, 1'b1, 1'b1},  // R1 write in setup
    {1'b1, 1'b1, 16'hBFFF, 8'hF7, 1'b0, 1'b1}   // R2 sel 3
  };

  task automatic check(input string req, input logic [7:0] es,
                       input logic eo, input logic ew, input logic [11:0] ea);
    n_vec++;
    if (sel_n !== es || oe_n !== eo || we_n !== ew || dev_addr !== ea) begin
      n_bad++;
      $display("FAIL %s addr=%h e=%b rw=%b: sel=%h oe=%b we=%b da=%h, expected sel=%h oe=%b we=%b da=%h",
               req, bus_addr, bus_e, bus_rd_wr_n, sel_n, oe_n, we_n, dev_addr,
               es, eo, ew, ea);
    end
  endtask

  task automatic apply(input logic e, input logic rw, input logic [15:0] a);
    @(posedge clk);
    bus_e = e;
    bus_rd_wr_n = rw;
    bus_addr = a;
    @(negedge clk);
  endtask

  // Expected outputs derived from R1..R6
  function automatic logic [9:0] model(input logic e, input logic rw, input logic [15:0] a);
    logic [7:0] s;
    logic act;
    act = e && a[15];
    s = act ? ~(8'h01 << a[14:12]) : 8'hFF;
    return {s, !(act && rw), !(act && !rw)};
  endfunction

  initial begin
    logic [9:0] m;
    repeat (4) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle state", 8'hFF, 1'b1, 1'b1, 12'h000);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][27], VEC[i][26], VEC[i][25:10]);
      check("R1-R7 vector", VEC[i][9:2], VEC[i][1], VEC[i][0], VEC[i][21:10]);
    end

    // Full sweep, both phases of E; R6 pass-through checked each step.
    for (int e = 0; e < 2; e++) begin
      for (int a = 0; a < 65536; a++) begin
        logic rw;
        rw = a[0] ^ a[13] ^ e[0];
        apply(e[0], rw, a[15:0]);
        m = model(e[0], rw, a[15:0]);
        check(e == 0 ? "R1 R6 sweep" : "R2 R3 R4 R5 R6 R7 R8 sweep",
              m[9:2], m[1], m[0], a[11:0]);
      end
    end
    done = 1'b1;
  end

  always @(posedge clk) begin
    if (rst) cycles <= 0;
    else cycles <= cycles + 1;
  end

  initial begin
    wait (done || cycles >= 190000);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, cycles=%0d expected < 190000", cycles);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule